// File: doc/BRIEF.md
# Control and Status Register Bank

This block is a bank of 32-bit, word-addressed registers behind a plain slave bus made of an address, a write strobe, a read strobe and a data word in each direction. It holds a fixed firmware revision word, a scratch register, an output data word, an output driver enable word, a front-panel LED source select and a command register. It also reports the state of the timestamp clock PLL.

Some addresses do not store what is written to them. Instead they fire one-cycle control strobes: scaler latch and clear, a FIFO read request, sync arm and sync go, a reset pulse and a reconfigure request. One address fires a reboot request, but only when the written word is exactly the bitwise inverse of the revision word. The bus adapter, the flash programmer and the reconfiguration hardware sit outside this block. They see reset, reconfigure and reboot only as output pulses.

Top module: `csr_bank`

## Requirements
- R1: A read of address 0 returns the parameter REVISION. A write to address 0 leaves that value unchanged.
- R2: A write to address 0 pulses outputs from the written bits: bit 0 `latchScalers`, bit 1 `zeroScalers`, bit 2 `fifoRdReq`, bit 5 `armSync`, bit 6 `syncGo`. Each pulse is high for exactly the one cycle after the write edge, and a clear written bit gives no pulse.
- R3: In a write to address 0, bit 3 clears the persistent `extClkSel` flag and bit 4 sets it. When both bits are set, set wins. When neither is set, the flag holds its value.
- R4: A write to address 1 stores the word, which reads back unchanged. A value of 1 pulses `resetCmd` for one cycle and a value of 2 pulses `reconfigCmd` for one cycle. Any other value pulses neither.
- R5: A write to address 14 (0xE) whose data equals ~REVISION pulses `rebootReq` for one cycle. Any other data gives no pulse. Address 14 reads as zero.
- R6: Address 4 is a full 32-bit read/write scratch register.
- R7: Address 11 (0xB) stores the 32-bit `outData` word. Address 13 (0xD) stores `outEnable`, and only bits 31:24 and 17:0 are kept (OE_MASK = 0xFF03FFFF). The other bits read as zero and drive zero.
- R8: Address 2 stores the LED source select in bits 3:0, which drive `ledSel`. The upper bits read as zero.
- R9: Address 28 (0x1C) reads the PLL status: bit 31 locked, bit 30 active clock (1 = external), bit 29 external clock bad, bit 28 internal clock bad, bit 27 `extClkSel`. Bits 26:0 are zero.
- R10: Writes to read-only addresses (0 for storage, 28) and to unmapped addresses change no stored state. Unmapped addresses read as zero.
- R11: While `rst` is high at a clock edge (synchronous reset), all writable registers, `extClkSel`, all pulses and `busRdata` clear to zero.
- R12: `busRdata` is registered. It shows the addressed word in the cycle after the `busRd` edge and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Word address |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pllLocked | input | 1 | PLL lock indication |
| pllActiveExt | input | 1 | PLL running from the external clock |
| extClkBad | input | 1 | External reference bad |
| intClkBad | input | 1 | Internal reference bad |
| latchScalers | output | 1 | Scaler latch strobe |
| zeroScalers | output | 1 | Scaler clear strobe |
| fifoRdReq | output | 1 | FIFO read request strobe |
| armSync | output | 1 | Sync arm strobe |
| syncGo | output | 1 | Sync activate strobe |
| resetCmd | output | 1 | Reset command pulse |
| reconfigCmd | output | 1 | Reconfigure command pulse |
| rebootReq | output | 1 | Keyed reboot request pulse |
| extClkSel | output | 1 | Persistent external clock select flag |
| ledSel | output | LED_SEL_W | LED source select |
| outData | output | 32 | Output data word |
| outEnable | output | 32 | Output driver enables |

## Verification
The bench sweeps all 128 combinations of the low seven bits written to address 0. A decoder with swapped or sticky strobes, or with clear winning over set on the clock flag, would show a wrong pulse vector or a wrong flag. It writes the reboot key and 32 single-bit corruptions of it. A partial key compare would then fire a reboot on a near-miss. Every address is written with a distinct pattern and then read back, so that an aliased decode or a write to a read-only or unmapped address corrupts some other word. Separate passes cover the masked enable bits, the 16 PLL status input combinations, read data holding between reads, and the clearing of every register by reset.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int DATA_W    = 32;
  localparam int A_REV     = 0;
  localparam int A_CMD     = 1;
  localparam int A_LED     = 2;
  localparam int A_TEST    = 4;
  localparam int A_OUTDATA = 11;
  localparam int A_OUTEN   = 13;
  localparam int A_KEY     = 14;
  localparam int A_PLL     = 28;

  localparam int CMD_RESET    = 1;
  localparam int CMD_RECONFIG = 2;

  // register write enables from the control decode
  typedef struct packed {
    logic cmd;
    logic led;
    logic test;
    logic outData;
    logic outEn;
    logic clkSet;
    logic clkClr;
  } wrSel_t;

  // registered one-cycle strobes
  typedef struct packed {
    logic latchScalers;
    logic zeroScalers;
    logic fifoRdReq;
    logic armSync;
    logic syncGo;
    logic resetCmd;
    logic reconfigCmd;
    logic reboot;
  } pulse_t;

endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_bank_pkg::*;
#(
  parameter int                ADDR_W   = 5,
  parameter logic [DATA_W-1:0] REVISION = 32'h5B6D_E806
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output wrSel_t            wrSel,
  output pulse_t            pulses
);

  localparam logic [ADDR_W-1:0] AdrRev  = ADDR_W'(A_REV);
  localparam logic [ADDR_W-1:0] AdrCmd  = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] AdrLed  = ADDR_W'(A_LED);
  localparam logic [ADDR_W-1:0] AdrTest = ADDR_W'(A_TEST);
  localparam logic [ADDR_W-1:0] AdrOut  = ADDR_W'(A_OUTDATA);
  localparam logic [ADDR_W-1:0] AdrOe   = ADDR_W'(A_OUTEN);
  localparam logic [ADDR_W-1:0] AdrKey  = ADDR_W'(A_KEY);
  localparam logic [DATA_W-1:0] RebootKey = ~REVISION;

  logic   hitRev, hitCmd, hitKey;
  pulse_t pulseNext;

  always_comb begin
    hitRev = busWr && (busAddr == AdrRev);
    hitCmd = busWr && (busAddr == AdrCmd);
    hitKey = busWr && (busAddr == AdrKey);

    wrSel         = '0;
    wrSel.cmd     = hitCmd;
    wrSel.led     = busWr && (busAddr == AdrLed);
    wrSel.test    = busWr && (busAddr == AdrTest);
    wrSel.outData = busWr && (busAddr == AdrOut);
    wrSel.outEn   = busWr && (busAddr == AdrOe);
    wrSel.clkClr  = hitRev && busWdata[3];
    wrSel.clkSet  = hitRev && busWdata[4];

    pulseNext              = '0;
    pulseNext.latchScalers = hitRev && busWdata[0];
    pulseNext.zeroScalers  = hitRev && busWdata[1];
    pulseNext.fifoRdReq    = hitRev && busWdata[2];
    pulseNext.armSync      = hitRev && busWdata[5];
    pulseNext.syncGo       = hitRev && busWdata[6];
    pulseNext.resetCmd     = hitCmd && (busWdata == DATA_W'(CMD_RESET));
    pulseNext.reconfigCmd  = hitCmd && (busWdata == DATA_W'(CMD_RECONFIG));
    pulseNext.reboot       = hitKey && (busWdata == RebootKey);
  end

  always_ff @(posedge clk) begin
    if (rst) pulses <= '0;
    else     pulses <= pulseNext;
  end

  // R2: a scaler latch strobe only follows a matching write to address 0
  p_latch_src_r2: assert property (@(posedge clk) disable iff (rst)
    pulses.latchScalers |-> $past(!rst && busWr && busAddr == AdrRev && busWdata[0]));

  // R2: the sync strobe only follows a matching write to address 0
  p_sync_src_r2: assert property (@(posedge clk) disable iff (rst)
    pulses.syncGo |-> $past(!rst && busWr && busAddr == AdrRev && busWdata[6]));

  // R4: the reset and reconfigure pulses are never high together
  p_cmd_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(pulses.resetCmd && pulses.reconfigCmd));

  // R4: a reset pulse follows a command write of value 1
  p_cmd_reset_r4: assert property (@(posedge clk) disable iff (rst)
    pulses.resetCmd |-> $past(!rst && busWr && busAddr == AdrCmd && busWdata == 32'd1));

  // R5: a reboot only follows the exact inverted revision key
  p_reboot_key_r5: assert property (@(posedge clk) disable iff (rst)
    pulses.reboot |-> $past(!rst && busWr && busAddr == AdrKey && busWdata == ~REVISION));

endmodule

// File: rtl/csr_data.sv
module csr_data
  import csr_bank_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter int                LED_SEL_W = 4,
  parameter logic [DATA_W-1:0] REVISION  = 32'h5B6D_E806,
  parameter logic [DATA_W-1:0] OE_MASK   = 32'hFF03_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wrSel_t               wrSel,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busRd,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic                 pllLocked,
  input  logic                 pllActiveExt,
  input  logic                 extClkBad,
  input  logic                 intClkBad,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 extClkSel,
  output logic [LED_SEL_W-1:0] ledSel,
  output logic [DATA_W-1:0]    outData,
  output logic [DATA_W-1:0]    outEnable
);

  localparam int PllFlags = 5;
  localparam int PllPad   = DATA_W - PllFlags;
  localparam int LedPad   = DATA_W - LED_SEL_W;

  logic [DATA_W-1:0] cmdReg, testReg, readMux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdReg    <= '0;
      testReg   <= '0;
      outData   <= '0;
      ledSel    <= '0;
      extClkSel <= 1'b0;
    end else begin
      if (wrSel.cmd)     cmdReg  <= busWdata;
      if (wrSel.test)    testReg <= busWdata;
      if (wrSel.outData) outData <= busWdata;
      if (wrSel.led)     ledSel  <= busWdata[LED_SEL_W-1:0];
      if (wrSel.clkSet)      extClkSel <= 1'b1;
      else if (wrSel.clkClr) extClkSel <= 1'b0;
    end
  end

  // enable bits exist only where the mask asks for them
  for (genvar i = 0; i < DATA_W; i++) begin : gOe
    if (OE_MASK[i]) begin : gKeep
      logic oeBit;
      always_ff @(posedge clk) begin
        if (rst)              oeBit <= 1'b0;
        else if (wrSel.outEn) oeBit <= busWdata[i];
      end
      assign outEnable[i] = oeBit;
    end else begin : gTie
      assign outEnable[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (int'(busAddr))
      A_REV:     readMux = REVISION;
      A_CMD:     readMux = cmdReg;
      A_LED:     readMux = {{LedPad{1'b0}}, ledSel};
      A_TEST:    readMux = testReg;
      A_OUTDATA: readMux = outData;
      A_OUTEN:   readMux = outEnable;
      A_PLL:     readMux = {pllLocked, pllActiveExt, extClkBad, intClkBad,
                            extClkSel, {PllPad{1'b0}}};
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        busRdata <= '0;
    else if (busRd) busRdata <= readMux;
  end

  // R1: reading address 0 always yields the revision
  p_rev_read_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busRd && busAddr == ADDR_W'(A_REV)) |-> busRdata == REVISION);

  // R3: set takes effect, and wins over clear
  p_clk_set_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wrSel.clkSet) |-> extClkSel);

  // R3: the flag holds when neither control bit is written
  p_clk_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wrSel.clkSet && !wrSel.clkClr) |-> $stable(extClkSel));

  // R7: masked-off enable bits never rise
  p_oe_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (outEnable & ~OE_MASK) == '0);

  // R10: an unmapped read yields zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && busRd && !(busAddr inside {ADDR_W'(A_REV), ADDR_W'(A_CMD),
      ADDR_W'(A_LED), ADDR_W'(A_TEST), ADDR_W'(A_OUTDATA), ADDR_W'(A_OUTEN),
      ADDR_W'(A_PLL)})) |-> busRdata == '0);

  // R12: read data holds between reads
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !busRd) |-> $stable(busRdata));

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int          ADDR_W    = 5,
  parameter int          LED_SEL_W = 4,
  parameter logic [31:0] REVISION  = 32'h5B6D_E806,
  parameter logic [31:0] OE_MASK   = 32'hFF03_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 pllLocked,
  input  logic                 pllActiveExt,
  input  logic                 extClkBad,
  input  logic                 intClkBad,
  output logic                 latchScalers,
  output logic                 zeroScalers,
  output logic                 fifoRdReq,
  output logic                 armSync,
  output logic                 syncGo,
  output logic                 resetCmd,
  output logic                 reconfigCmd,
  output logic                 rebootReq,
  output logic                 extClkSel,
  output logic [LED_SEL_W-1:0] ledSel,
  output logic [31:0]          outData,
  output logic [31:0]          outEnable
);

  wrSel_t wrSel;
  pulse_t pulses;

  csr_ctrl #(.ADDR_W(ADDR_W), .REVISION(REVISION)) ctrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .wrSel    (wrSel),
    .pulses   (pulses)
  );

  csr_data #(
    .ADDR_W(ADDR_W), .LED_SEL_W(LED_SEL_W),
    .REVISION(REVISION), .OE_MASK(OE_MASK)
  ) data (
    .clk          (clk),
    .rst          (rst),
    .wrSel        (wrSel),
    .busAddr      (busAddr),
    .busRd        (busRd),
    .busWdata     (busWdata),
    .pllLocked    (pllLocked),
    .pllActiveExt (pllActiveExt),
    .extClkBad    (extClkBad),
    .intClkBad    (intClkBad),
    .busRdata     (busRdata),
    .extClkSel    (extClkSel),
    .ledSel       (ledSel),
    .outData      (outData),
    .outEnable    (outEnable)
  );

  assign latchScalers = pulses.latchScalers;
  assign zeroScalers  = pulses.zeroScalers;
  assign fifoRdReq    = pulses.fifoRdReq;
  assign armSync      = pulses.armSync;
  assign syncGo       = pulses.syncGo;
  assign resetCmd     = pulses.resetCmd;
  assign reconfigCmd  = pulses.reconfigCmd;
  assign rebootReq    = pulses.reboot;

endmodule

// File: tb/csr_bank_test.sv
`timescale 1ns/1ps
module csr_bank_test;

  localparam logic [31:0] REV  = 32'h5B6D_E806;
  localparam logic [31:0] MASK = 32'hFF03_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic        pllLocked = 0, pllActiveExt = 0, extClkBad = 0, intClkBad = 0;
  logic        latchScalers, zeroScalers, fifoRdReq, armSync, syncGo;
  logic        resetCmd, reconfigCmd, rebootReq, extClkSel;
  logic [3:0]  ledSel;
  logic [31:0] outData, outEnable;
  logic [7:0]  pv;

  int total = 0, bad = 0;

  // model state
  logic [31:0] mCmd = 0, mTest = 0, mOut = 0, mOe = 0;
  logic [3:0]  mLed = 0;
  logic        mClk = 0;

  always #5 clk = ~clk;

  csr_bank uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata),
    .pllLocked(pllLocked), .pllActiveExt(pllActiveExt),
    .extClkBad(extClkBad), .intClkBad(intClkBad),
    .latchScalers(latchScalers), .zeroScalers(zeroScalers),
    .fifoRdReq(fifoRdReq), .armSync(armSync), .syncGo(syncGo),
    .resetCmd(resetCmd), .reconfigCmd(reconfigCmd), .rebootReq(rebootReq),
    .extClkSel(extClkSel), .ledSel(ledSel), .outData(outData),
    .outEnable(outEnable)
  );

  assign pv = {latchScalers, zeroScalers, fifoRdReq, armSync, syncGo,
               resetCmd, reconfigCmd, rebootReq};

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int a);
    case (a)
      0:       return REV;
      1:       return mCmd;
      2:       return {28'b0, mLed};
      4:       return mTest;
      11:      return mOut;
      13:      return mOe;
      28:      return {pllLocked, pllActiveExt, extClkBad, intClkBad, mClk, 27'b0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] expPulse(input int a, input logic [31:0] d);
    logic [7:0] p = '0;
    if (a == 0)  p[7:3] = {d[0], d[1], d[2], d[5], d[6]};
    if (a == 1)  p[2:1] = {d == 32'd1, d == 32'd2};
    if (a == 14) p[0]   = (d == ~REV);
    return p;
  endfunction

  // write, then check the pulse cycle, the cycle after, and the storage ports
  task automatic wrReg(input int a, input logic [31:0] d, input string req);
    logic [7:0] snap, after;
    logic [7:0] ep = expPulse(a, d);
    @(negedge clk);
    busAddr = 5'(a); busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    snap = pv;
    @(negedge clk);
    after = pv;
    case (a)
      0: if (d[4]) mClk = 1'b1; else if (d[3]) mClk = 1'b0;
      1: mCmd = d;
      2: mLed = d[3:0];
      4: mTest = d;
      11: mOut = d;
      13: mOe = d & MASK;
      default: ;
    endcase
    chk(snap == ep, req, {24'b0, snap}, {24'b0, ep});
    chk(after == 8'h0, req, {24'b0, after}, 32'h0);
    chk(extClkSel == mClk, "R3", {31'b0, extClkSel}, {31'b0, mClk});
    chk(ledSel == mLed && outData == mOut && outEnable == mOe, "R10",
        outEnable ^ outData, mOe ^ mOut);
  endtask

  task automatic rdReg(input int a, output logic [31:0] v);
    @(negedge clk);
    busAddr = 5'(a); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    v = busRdata;
  endtask

  task automatic rdChk(input int a, input string req);
    logic [31:0] v;
    rdReg(a, v);
    chk(v == expRead(a), req, v, expRead(a));
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state at the ports
    chk(pv == 0 && !extClkSel && ledSel == 0 && outData == 0 && outEnable == 0
        && busRdata == 0, "R11", outData | outEnable, 32'h0);

    // R2 / R3: sweep the low seven bits of an address-0 write
    for (int i = 0; i < 128; i++) wrReg(0, 32'(i), "R2");
    rdChk(0, "R1");
    wrReg(0, 32'hFFFF_FFFF, "R2");
    rdChk(0, "R1");
    // R3: both bits set, set wins, then clear alone, then hold
    wrReg(0, 32'h18, "R3");
    wrReg(0, 32'h08, "R3");
    wrReg(0, 32'h00, "R3");

    // R4: command values
    for (int c = 0; c < 5; c++) begin
      wrReg(1, 32'(c), "R4");
      rdChk(1, "R4");
    end
    wrReg(1, 32'h0001_0001, "R4");
    rdChk(1, "R4");

    // R5: exact key, and every single-bit corruption of it
    wrReg(14, ~REV, "R5");
    for (int b = 0; b < 32; b++) wrReg(14, ~REV ^ (32'h1 << b), "R5");
    wrReg(14, REV, "R5");
    rdChk(14, "R5");

    // R6 / R7 / R8: dedicated patterns
    wrReg(4, 32'hA5A5_5A5A, "R6"); rdChk(4, "R6");
    wrReg(4, 32'h0, "R6");         rdChk(4, "R6");
    wrReg(11, 32'hDEAD_BEEF, "R7"); rdChk(11, "R7");
    wrReg(13, 32'hFFFF_FFFF, "R7"); rdChk(13, "R7");
    wrReg(13, 32'h00FC_0000, "R7"); rdChk(13, "R7");
    wrReg(2, 32'hFFFF_FFF9, "R8");  rdChk(2, "R8");

    // R10: write every address with a distinct word, then read all back
    for (int a = 0; a < 32; a++) begin
      logic [31:0] d = (32'(a) + 1) * 32'h9E37_79B1;
      if (a == 14) d = d ^ 32'h1;
      wrReg(a, d, "R10");
    end
    for (int a = 0; a < 32; a++) rdChk(a, "R10");

    // R9: every PLL input combination, both flag values
    for (int f = 0; f < 2; f++) begin
      wrReg(0, f ? 32'h10 : 32'h08, "R3");
      for (int s = 0; s < 16; s++) begin
        {pllLocked, pllActiveExt, extClkBad, intClkBad} = 4'(s);
        rdChk(28, "R9");
      end
    end

    // R12: read data holds across idle cycles and writes
    rdReg(4, v);
    wrReg(4, 32'h1234_5678, "R6");
    repeat (3) @(negedge clk);
    chk(busRdata == v, "R12", busRdata, v);
    rdChk(4, "R12");

    // R11: reset clears everything
    wrReg(0, 32'h10, "R3");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    mCmd = 0; mTest = 0; mOut = 0; mOe = 0; mLed = 0; mClk = 0;
    chk(pv == 0 && !extClkSel && ledSel == 0 && outData == 0 &&
        outEnable == 0 && busRdata == 0, "R11", outData | outEnable, 32'h0);
    for (int a = 0; a < 32; a++) rdChk(a, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule